// File: doc/BRIEF.md
# Dual-Latch Speed and Direction Decoder

This block turns two streams of signed magnetic-field samples into a speed level and a rotation-direction level. The two sensing channels sit a little apart along the path of a rotating pole wheel. Each channel has a hysteresis latch. A field above the operate threshold switches the latch on. A field below the release threshold switches it off. A field between the two thresholds leaves it as it was. Both output levels model open-drain pins, so a high level means the pin is off.

The speed output follows the first channel's latch, inverted: an active latch pulls speed low. Direction is decoded from the order in which the two latches switch, in the same way as a quadrature pair. The direction output is updated on the edge where a latch changes. The matching speed edge comes a programmable number of cycles later, so a counter downstream always sees the new direction before the speed edge it qualifies. After reset there is a power-on interval. During it every sample is ignored and both outputs stay off. After it, each latch stays undecided until its field first leaves the hysteresis band.

Top module: `spd_dir_decoder`

## Requirements
- R1: An accepted sample with a field strictly greater than `opThresh` sets that channel's latch active. For channel A this drives `speedOut` low. A field equal to `opThresh` does not count as a crossing.
- R2: An accepted sample with a field strictly less than `relThresh` sets that channel's latch inactive. For channel A this drives `speedOut` high. A field equal to `relThresh` does not count as a crossing.
- R3: An accepted sample whose field lies in the closed range from `relThresh` to `opThresh` leaves that channel's latch unchanged.
- R4: While reset is asserted, and for `PON_CYCLES` clock cycles after it is released, `speedOut` and `dirOut` are both 1. Samples offered in that interval are ignored. Their fields leave no trace in either latch afterwards.
- R5: `dirOut` = 1 means clockwise and `dirOut` = 0 means counterclockwise. Clockwise means that channel A switches into a state that differs from channel B's state, or that channel B switches into the state channel A already holds. The opposite case means counterclockwise. A change in the order of switching reverses `dirOut`.
- R6: `dirOut` stays 1 until both channels have made at least one valid crossing. A channel's first crossing out of the undecided state does not decode a direction.
- R7: `opThresh` must be strictly greater than `relThresh` whenever the block is out of reset.
- R8: `speedOut` takes the inverse of channel A's latch exactly `spdDelay`+1 cycles after the edge at which that latch changed. A further change of channel A before then restarts the wait, and only the latest latch value is presented.
- R9: If both latches change on the same sample, `dirOut` keeps its previous value.
- R10: Latches and `dirOut` change only at the clock edge where `sampleValid` is high after the power-on interval. The new `dirOut` is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleValid | input | 1 | Field words are valid in this cycle |
| fieldA | input | FIELD_W | Signed field sample, channel A |
| fieldB | input | FIELD_W | Signed field sample, channel B |
| opThresh | input | FIELD_W | Signed operate threshold |
| relThresh | input | FIELD_W | Signed release threshold |
| spdDelay | input | DLY_W | Direction-to-speed delay in cycles, minus one |
| speedOut | output | 1 | Speed level, low while channel A is active, high = off |
| dirOut | output | 1 | Direction level, 1 = clockwise, 0 = counterclockwise |

## Verification
The bench first runs directed sequences.
- A clockwise cycle through all four latch states and a counterclockwise cycle. These separate the two decode rules, because each rule alone would get half of the steps wrong.
- Samples placed inside the power-on window, followed by an in-band sample. These show that a latch did not quietly take an early field.
- First crossings on one channel only. These show that direction is held until both channels have decided.
- Fields exactly at each threshold, and a simultaneous change of both latches.
- A second change of channel A inside the delay window. This separates a restarting timer from a free-running one.

Random fields are then drawn above, below, inside and exactly on the band edges, under three threshold settings and with delays from zero upward. Every sample's direction is checked, along with the speed level one cycle before and on the cycle of its expected change.

// File: rtl/spd_dir_pkg.sv
package spd_dir_pkg;

  localparam int NUM_CH = 2;
  localparam int CH_SPEED = 0;

  localparam logic DIR_CW = 1'b1;
  localparam logic DIR_CCW = 1'b0;
  localparam logic PIN_OFF = 1'b1;

  typedef struct packed {
    logic sampleEn;
    logic speedLoad;
  } ctlStrobe_t;

endpackage

// File: rtl/hyst_latch.sv
module hyst_latch #(
  parameter int FIELD_W = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sampleEn,
  input  logic signed [FIELD_W-1:0] field,
  input  logic signed [FIELD_W-1:0] opThresh,
  input  logic signed [FIELD_W-1:0] relThresh,
  output logic                      latchOn,
  output logic                      latchValid,
  output logic                      nextOn,
  output logic                      nextValid
);

  logic aboveOp;
  logic belowRel;

  assign aboveOp  = field > opThresh;
  assign belowRel = field < relThresh;

  always_comb begin
    nextOn    = latchOn;
    nextValid = latchValid;
    if (sampleEn) begin
      if (aboveOp) begin
        nextOn    = 1'b1;
        nextValid = 1'b1;
      end else if (belowRel) begin
        nextOn    = 1'b0;
        nextValid = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchOn    <= 1'b0;
      latchValid <= 1'b0;
    end else begin
      latchOn    <= nextOn;
      latchValid <= nextValid;
    end
  end

  AST_OP_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && (field > opThresh)) |=> (latchOn && latchValid)); // R1

  AST_REL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && (field < relThresh)) |=> (!latchOn && latchValid)); // R2

  AST_BAND_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && (field <= opThresh) && (field >= relThresh))
      |=> ($stable(latchOn) && $stable(latchValid))); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn |=> ($stable(latchOn) && $stable(latchValid))); // R10

  AST_THRESH_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    opThresh > relThresh); // R7

endmodule

// File: rtl/spd_dir_control.sv
module spd_dir_control
  import spd_dir_pkg::*;
#(
  parameter int DLY_W      = 8,
  parameter int PON_CYCLES = 4200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [DLY_W-1:0] spdDelay,
  input  logic             ch1Change,
  output ctlStrobe_t       strobe,
  output logic             ponDone
);

  localparam int PON_W = $clog2(PON_CYCLES + 1);
  localparam logic [PON_W-1:0] PON_LAST = PON_W'(PON_CYCLES - 1);

  logic [PON_W-1:0] ponCnt;
  logic             armed;
  logic [DLY_W-1:0] waitCnt;

  // Power-on hold-off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ponCnt  <= '0;
      ponDone <= 1'b0;
    end else if (!ponDone) begin
      if (ponCnt == PON_LAST) begin
        ponDone <= 1'b1;
      end else begin
        ponCnt <= ponCnt + 1'b1;
      end
    end
  end

  // Direction-to-speed wait, restarted by every channel A change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      waitCnt <= '0;
    end else if (ch1Change) begin
      armed   <= 1'b1;
      waitCnt <= spdDelay;
    end else if (armed) begin
      if (waitCnt == '0) begin
        armed <= 1'b0;
      end else begin
        waitCnt <= waitCnt - 1'b1;
      end
    end
  end

  always_comb begin
    strobe.sampleEn  = sampleValid && ponDone;
    strobe.speedLoad = armed && (waitCnt == '0);
  end

  AST_PON_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ponDone |=> ponDone); // R4

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.speedLoad && !ch1Change) |=> !strobe.speedLoad); // R8

  AST_CHANGE_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    ch1Change |=> (armed && !$stable(ponCnt) == 1'b0)); // R8

endmodule

// File: rtl/spd_dir_datapath.sv
module spd_dir_datapath
  import spd_dir_pkg::*;
#(
  parameter int FIELD_W = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobe_t                strobe,
  input  logic signed [FIELD_W-1:0] fieldA,
  input  logic signed [FIELD_W-1:0] fieldB,
  input  logic signed [FIELD_W-1:0] opThresh,
  input  logic signed [FIELD_W-1:0] relThresh,
  output logic                      ch1Change,
  output logic                      speedOut,
  output logic                      dirOut
);

  logic signed [FIELD_W-1:0] fieldArr [NUM_CH];
  logic [NUM_CH-1:0] latchOn;
  logic [NUM_CH-1:0] latchValid;
  logic [NUM_CH-1:0] nextOn;
  logic [NUM_CH-1:0] nextValid;
  logic [NUM_CH-1:0] toggled;
  logic              dirNext;

  assign fieldArr[0] = fieldA;
  assign fieldArr[1] = fieldB;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    hyst_latch #(.FIELD_W(FIELD_W)) u_latch (
      .clk        (clk),
      .rstN       (rstN),
      .sampleEn   (strobe.sampleEn),
      .field      (fieldArr[g]),
      .opThresh   (opThresh),
      .relThresh  (relThresh),
      .latchOn    (latchOn[g]),
      .latchValid (latchValid[g]),
      .nextOn     (nextOn[g]),
      .nextValid  (nextValid[g])
    );
  end

  // A toggle counts only when the channel had already decided
  assign toggled   = latchValid & (nextOn ^ latchOn);
  assign ch1Change = nextOn[CH_SPEED] ^ latchOn[CH_SPEED];

  always_comb begin
    dirNext = dirOut;
    if (toggled[0] && !toggled[1] && nextValid[1]) begin
      dirNext = (nextOn[0] ^ nextOn[1]) ? DIR_CW : DIR_CCW;
    end else if (toggled[1] && !toggled[0] && nextValid[0]) begin
      dirNext = (nextOn[0] ^ nextOn[1]) ? DIR_CCW : DIR_CW;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirOut   <= PIN_OFF;
      speedOut <= PIN_OFF;
    end else begin
      dirOut <= dirNext;
      if (strobe.speedLoad) begin
        speedOut <= ~latchOn[CH_SPEED];
      end
    end
  end

  AST_DIR_UNDECIDED: assert property (@(posedge clk) disable iff (!rstN)
    !(latchValid[0] && latchValid[1]) |-> dirOut); // R6

  AST_DIR_SIMULT: assert property (@(posedge clk) disable iff (!rstN)
    (toggled == 2'b11) |=> $stable(dirOut)); // R9

  AST_SPEED_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(speedOut) |-> $past(strobe.speedLoad)); // R8

  AST_DIR_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dirOut) |-> $past(strobe.sampleEn)); // R10

endmodule

// File: rtl/spd_dir_decoder.sv
module spd_dir_decoder
  import spd_dir_pkg::*;
#(
  parameter int FIELD_W    = 12,
  parameter int DLY_W      = 8,
  parameter int PON_CYCLES = 4200
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sampleValid,
  input  logic signed [FIELD_W-1:0] fieldA,
  input  logic signed [FIELD_W-1:0] fieldB,
  input  logic signed [FIELD_W-1:0] opThresh,
  input  logic signed [FIELD_W-1:0] relThresh,
  input  logic [DLY_W-1:0]          spdDelay,
  output logic                      speedOut,
  output logic                      dirOut
);

  ctlStrobe_t strobe;
  logic       ponDone;
  logic       ch1Change;

  spd_dir_control #(
    .DLY_W      (DLY_W),
    .PON_CYCLES (PON_CYCLES)
  ) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .spdDelay    (spdDelay),
    .ch1Change   (ch1Change),
    .strobe      (strobe),
    .ponDone     (ponDone)
  );

  spd_dir_datapath #(.FIELD_W(FIELD_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .fieldA    (fieldA),
    .fieldB    (fieldB),
    .opThresh  (opThresh),
    .relThresh (relThresh),
    .ch1Change (ch1Change),
    .speedOut  (speedOut),
    .dirOut    (dirOut)
  );

  AST_PON_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !ponDone |-> (speedOut && dirOut)); // R4

endmodule

// File: tb/test_spd_dir_decoder.sv
module test_spd_dir_decoder;

  localparam int FW  = 12;
  localparam int DW  = 8;
  localparam int PON = 4200;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleValid = 1'b0;
  logic [FW-1:0] fieldA = '0;
  logic [FW-1:0] fieldB = '0;
  logic [FW-1:0] opThresh;
  logic [FW-1:0] relThresh;
  logic [DW-1:0] spdDelay;
  logic          speedOut;
  logic          dirOut;

  int checks = 0;
  int failures = 0;
  int cycleCnt = 0;
  bit done = 0;

  int op = 100;
  int rel = -100;
  int curDelay = 20;

  // Reference state
  logic m1, m2, v1, v2, mDir, mSpd;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) cycleCnt <= 0;
    else cycleCnt <= cycleCnt + 1;
  end

  spd_dir_decoder i_spd_dir_decoder (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .fieldA      (fieldA),
    .fieldB      (fieldB),
    .opThresh    (opThresh),
    .relThresh   (relThresh),
    .spdDelay    (spdDelay),
    .speedOut    (speedOut),
    .dirOut      (dirOut)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, exp, cycleCnt);
    end
  endtask

  function automatic int classify(int f);
    if (f > op) return 2;
    if (f < rel) return 1;
    return 0;
  endfunction

  function automatic int pickField(int kind);
    case (kind)
      0: return op + 1 + int'($urandom % 100);
      1: return rel - 1 - int'($urandom % 100);
      2: return rel + int'($urandom % (op - rel + 1));
      3: return op;
      default: return rel;
    endcase
  endfunction

  task automatic setThresh(int o, int r);
    op = o;
    rel = r;
    opThresh = FW'(o);
    relThresh = FW'(r);
  endtask

  task automatic setDelay(int d);
    curDelay = d;
    spdDelay = DW'(d);
  endtask

  task automatic modelReset();
    m1 = 0; m2 = 0; v1 = 0; v2 = 0; mDir = 1; mSpd = 1;
  endtask

  task automatic modelStep(int a, int b);
    int ca, cb;
    logic n1, n2, nv1, nv2, t1, t2;
    ca = classify(a);
    cb = classify(b);
    n1 = (ca == 2) ? 1'b1 : (ca == 1) ? 1'b0 : m1;
    n2 = (cb == 2) ? 1'b1 : (cb == 1) ? 1'b0 : m2;
    nv1 = v1 | (ca != 0);
    nv2 = v2 | (cb != 0);
    t1 = v1 && (n1 != m1);
    t2 = v2 && (n2 != m2);
    // clockwise: A moves away from B, or B moves onto A
    if (t1 && !t2 && nv2) mDir = (n1 != n2);
    else if (t2 && !t1 && nv1) mDir = (n2 == n1);
    m1 = n1; m2 = n2; v1 = nv1; v2 = nv2;
    mSpd = ~m1;
  endtask

  // Called at a negedge, returns at the negedge after the sampling edge
  task automatic drive(int a, int b);
    fieldA = FW'(a);
    fieldB = FW'(b);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic speedTiming(string req, logic oldSpd, logic newSpd);
    repeat (curDelay) @(negedge clk);
    chk(req, speedOut, oldSpd);
    @(negedge clk);
    chk(req, speedOut, newSpd);
  endtask

  task automatic step(string req, int a, int b);
    logic oldSpd;
    oldSpd = mSpd;
    drive(a, b);
    modelStep(a, b);
    chk({req, " dir"}, dirOut, mDir);
    speedTiming({req, " speed R8"}, oldSpd, mSpd);
    @(negedge clk);
  endtask

  task automatic stepExp(string req, int a, int b, logic expDir);
    step(req, a, b);
    chk({req, " literal dir"}, dirOut, expDir);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    setThresh(100, -100);
    setDelay(20);
    modelReset();

    // R4: reset state
    repeat (3) @(negedge clk);
    chk("R4 reset speed", speedOut, 1'b1);
    chk("R4 reset dir", dirOut, 1'b1);
    rstN = 1'b1;

    // R4: samples inside the power-on window are ignored
    repeat (20) @(negedge clk);
    drive(500, -500);
    repeat (curDelay + 3) @(negedge clk);
    chk("R4 early speed", speedOut, 1'b1);
    chk("R4 early dir", dirOut, 1'b1);
    while (cycleCnt != PON - 1) @(negedge clk);
    drive(500, 500);  // taken at edge PON, still inside the window
    repeat (curDelay + 3) @(negedge clk);
    chk("R4 last-window speed", speedOut, 1'b1);
    chk("R4 last-window dir", dirOut, 1'b1);

    // R4: in-band sample shows no latch captured the early fields
    step("R4 in-band after window", 0, 0);
    chk("R4 no trace", speedOut, 1'b1);

    // R6: first crossings do not decode direction
    stepExp("R6 A first", 500, 0, 1'b1);
    chk("R1 speed low", speedOut, 1'b0);
    stepExp("R6 B first", 0, -500, 1'b1);
    // A falls while B inactive: counterclockwise
    stepExp("R5 decode after both", -500, 0, 1'b0);
    chk("R2 speed high", speedOut, 1'b1);

    // R5: clockwise cycle
    stepExp("R5 cw1", 500, -500, 1'b1);
    stepExp("R5 cw2", 500, 500, 1'b1);
    stepExp("R5 cw3", -500, 500, 1'b1);
    stepExp("R5 cw4", -500, -500, 1'b1);
    // R5: counterclockwise cycle (reversal)
    stepExp("R5 ccw1", -500, 500, 1'b0);
    stepExp("R5 ccw2", 500, 500, 1'b0);
    stepExp("R5 ccw3", 500, -500, 1'b0);
    stepExp("R5 ccw4", -500, -500, 1'b0);

    // R1/R2/R3: exact threshold values are inside the band
    step("R3 at op", op, op);
    chk("R3 at op speed", speedOut, 1'b1);
    step("R3 set", 500, 500);
    step("R3 at rel", rel, rel);
    chk("R3 at rel speed", speedOut, 1'b0);

    // R9: simultaneous change keeps direction
    stepExp("R9 simult", -500, -500, 1'b0);
    stepExp("R9 simult up", 500, 500, 1'b0);
    step("R9 park", -500, -500);

    // R8: restart of the wait by a second channel A change
    setDelay(10);
    drive(500, -500);
    modelStep(500, -500);
    repeat (3) @(negedge clk);
    drive(-500, -500);
    modelStep(-500, -500);
    repeat (8) @(negedge clk);
    chk("R8 restart no early edge", speedOut, 1'b1);
    repeat (10) @(negedge clk);
    chk("R8 restart final", speedOut, 1'b1);

    // R8: zero delay
    setDelay(0);
    step("R8 zero delay up", 500, 0);
    step("R8 zero delay down", -500, 0);

    // Random phases under three threshold settings
    for (int ph = 0; ph < 3; ph++) begin
      if (ph == 0) setThresh(100, -100);
      else if (ph == 1) setThresh(60, 20);
      else setThresh(-10, -150);
      for (int i = 0; i < 120; i++) begin
        if (i % 20 == 0) setDelay(int'($urandom % 16));
        step("R1 R2 R3 R5 random", pickField(int'($urandom % 5)),
             pickField(int'($urandom % 5)));
      end
    end

    // R4: reset again mid-run
    rstN = 1'b0;
    @(negedge clk);
    chk("R4 rerun speed", speedOut, 1'b1);
    chk("R4 rerun dir", dirOut, 1'b1);
    rstN = 1'b1;
    drive(500, 500);
    repeat (30) @(negedge clk);
    chk("R4 rerun window speed", speedOut, 1'b1);
    chk("R4 rerun window dir", dirOut, 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule